// File: doc/BRIEF.md
# Synchronous Serial Clock Gating Controller

This block produces the serial bit clock that a synchronous-mode serial port drives when it is the clock master. The bit clock is a divided copy of the system clock, with each half period lasting a set number of system cycles. By default the bit clock is gated. It runs only while the transmitter reports a character in flight, or while the receiver reports that a character is still being assembled. Between characters it rests at a fixed idle level.

Two control bits change this gating. The free-run bit keeps the bit clock going with no transmit or receive activity, so a remote sender can clock characters in. The one-shot bit makes free-run mode end by itself. When a complete character has been received while the one-shot bit is set, both bits drop together. The bit clock then finishes the cycle it is in and stops at its idle level.

Gating only ever happens at whole-cycle boundaries, so the line never carries a shortened pulse. Shifting data in or out is handled elsewhere.

Top module: `sclk_gate_ctrl`

## Requirements
- R1: After reset, `sclk` sits at the idle level (parameter IDLE_LEVEL, 0 by default), and `free_run` and `one_shot` both read 0.
- R2: A cycle with `free_run_we` high loads `free_run_wd` into `free_run`, and a cycle with `one_shot_we` high loads `one_shot_wd` into `one_shot`. Both are visible one clock later. Without a write, each bit holds its value.
- R3: While the bit clock runs, every non-idle level of `sclk` lasts exactly HALF_DIV system cycles. In free-run mode, consecutive rising edges of `sclk` are exactly 2*HALF_DIV cycles apart.
- R4: With `free_run` at 0 and both `tx_busy` and `rx_active` low, `sclk` makes no pulse. With `tx_busy` high, `sclk` toggles.
- R5: With `rx_active` high alone, `sclk` toggles, so the receiver can finish a character.
- R6: With `free_run` at 1, `sclk` toggles with both `tx_busy` and `rx_active` low.
- R7: If `one_shot` is 1 when `rx_char_done` is high, then both `free_run` and `one_shot` read 0 one clock later.
- R8: If `one_shot` is 0, `rx_char_done` leaves `free_run` unchanged.
- R9: `sclk` runs only in whole cycles. A cycle starts when `sclk` leaves the idle level and ends when it returns to that level. When the run request goes away, the cycle in progress completes, with its full non-idle width, and `sclk` then stays at the idle level.
- R10: When the auto-clear of R7 and a write to `free_run` or `one_shot` fall in the same cycle, the auto-clear wins and both bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_busy | input | 1 | The transmitter has a character on the line |
| rx_active | input | 1 | The receiver is partway through a character |
| rx_char_done | input | 1 | One-cycle strobe: a complete character has been received |
| free_run_we | input | 1 | Write strobe for the free-run bit |
| free_run_wd | input | 1 | Value written to the free-run bit |
| one_shot_we | input | 1 | Write strobe for the one-shot bit |
| one_shot_wd | input | 1 | Value written to the one-shot bit |
| sclk | output | 1 | Gated serial bit clock |
| free_run | output | 1 | Current free-run bit |
| one_shot | output | 1 | Current one-shot bit |

## Verification
The hardest case to set up from the ports is a run request that disappears while `sclk` sits at its non-idle level. In that case the truncated-pulse guard must extend the cycle rather than cut it. To reach it, the bench holds `tx_busy` until it sees `sclk` at the non-idle level, then drops the request at once. The same thing happens after an auto-clear strobe that lands in the middle of a pulse. A bench-side monitor measures the width of every non-idle level seen during the whole run, and any width other than HALF_DIV counts against R3 and R9.

// File: rtl/sclkg_pkg.sv
package sclkg_pkg;

  // True when a half-period counter has reached its last count.
  function automatic logic half_period_end(input int unsigned cnt, input int unsigned half);
    return cnt == (half - 1);
  endfunction

  // The bit clock is needed while any requester wants it.
  function automatic logic want_clock(input logic free_run, input logic tx_busy,
                                      input logic rx_active);
    return free_run | tx_busy | rx_active;
  endfunction

endpackage

// File: rtl/sclkg_ctrl_bits.sv
module sclkg_ctrl_bits (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_char_done,
  input  logic fr_we,
  input  logic fr_wd,
  input  logic os_we,
  input  logic os_wd,
  output logic fr_q,
  output logic os_q,
  output logic auto_clear_ev
);

  assign auto_clear_ev = os_q & rx_char_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fr_q <= 1'b0;
      os_q <= 1'b0;
    end else if (auto_clear_ev) begin
      fr_q <= 1'b0;
      os_q <= 1'b0;
    end else begin
      if (fr_we) fr_q <= fr_wd;
      if (os_we) os_q <= os_wd;
    end
  end

  a_r7_auto_clear_both: assert property (@(posedge clk) disable iff (!rst_n)
    (os_q && rx_char_done) |=> (!fr_q && !os_q));

  a_r8_done_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (!os_q && rx_char_done && !fr_we) |=> (fr_q == $past(fr_q)));

  a_r2_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_we && !(os_q && rx_char_done)) |=> (fr_q == $past(fr_wd)));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!fr_we && !os_we && !rx_char_done) |=> (fr_q == $past(fr_q) && os_q == $past(os_q)));

endmodule

// File: rtl/sclkg_divider.sv
module sclkg_divider #(
  parameter int unsigned HALF_DIV   = 3,
  parameter logic        IDLE_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_req,
  output logic sclk_o,
  output logic running_o,
  output logic half_tick_o
);
  import sclkg_pkg::*;

  localparam int unsigned CW = $clog2(HALF_DIV + 1);

  logic [CW-1:0] cnt_q;
  logic          sclk_q;
  logic          run_q;
  logic          half_tick;
  logic          cycle_end;

  assign half_tick = run_q & half_period_end(int'(cnt_q), HALF_DIV);
  assign cycle_end = half_tick & (sclk_q != IDLE_LEVEL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= IDLE_LEVEL;
      run_q  <= 1'b0;
    end else if (!run_q) begin
      cnt_q  <= '0;
      sclk_q <= IDLE_LEVEL;
      if (run_req) run_q <= 1'b1;
    end else if (half_tick) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
      if (cycle_end && !run_req) run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sclk_o      = sclk_q;
  assign running_o   = run_q;
  assign half_tick_o = half_tick;

  a_r3_toggle_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sclk_q) |-> $past(half_tick));

  a_r9_stop_at_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> (sclk_q == IDLE_LEVEL));

  a_r9_idle_while_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (sclk_q == IDLE_LEVEL));

  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) < HALF_DIV);

endmodule

// File: rtl/sclk_gate_ctrl.sv
module sclk_gate_ctrl #(
  parameter int unsigned HALF_DIV   = 3,
  parameter logic        IDLE_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_busy,
  input  logic rx_active,
  input  logic rx_char_done,
  input  logic free_run_we,
  input  logic free_run_wd,
  input  logic one_shot_we,
  input  logic one_shot_wd,
  output logic sclk,
  output logic free_run,
  output logic one_shot
);
  import sclkg_pkg::*;

  logic fr_bit;
  logic os_bit;
  logic auto_clear_ev;
  logic run_req;
  logic running;
  logic half_tick;

  sclkg_ctrl_bits u_bits (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_char_done (rx_char_done),
    .fr_we        (free_run_we),
    .fr_wd        (free_run_wd),
    .os_we        (one_shot_we),
    .os_wd        (one_shot_wd),
    .fr_q         (fr_bit),
    .os_q         (os_bit),
    .auto_clear_ev(auto_clear_ev)
  );

  assign run_req = want_clock(fr_bit, tx_busy, rx_active);

  sclkg_divider #(
    .HALF_DIV  (HALF_DIV),
    .IDLE_LEVEL(IDLE_LEVEL)
  ) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_req    (run_req),
    .sclk_o     (sclk),
    .running_o  (running),
    .half_tick_o(half_tick)
  );

  assign free_run = fr_bit;
  assign one_shot = os_bit;

  a_r6_free_run_keeps_going: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_bit && running && !auto_clear_ev) |=> running);

  a_r10_clear_beats_write: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_clear_ev && free_run_we && free_run_wd) |=> !fr_bit);

  a_r4_no_start_without_request: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !run_req) |=> !running);

endmodule

// File: tb/sclk_gate_ctrl_test.sv
module sclk_gate_ctrl_test;
  localparam int unsigned HALF = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_busy = 0, rx_active = 0, rx_char_done = 0;
  logic free_run_we = 0, free_run_wd = 0, one_shot_we = 0, one_shot_wd = 0;
  logic sclk, free_run, one_shot;

  int n_checks = 0;
  int n_fail = 0;
  int pulses = 0;
  int bad_width = 0;
  int hi_run = 0;
  logic prev_sclk = 1'b0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sclk_gate_ctrl #(.HALF_DIV(HALF), .IDLE_LEVEL(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .tx_busy(tx_busy), .rx_active(rx_active),
    .rx_char_done(rx_char_done), .free_run_we(free_run_we), .free_run_wd(free_run_wd),
    .one_shot_we(one_shot_we), .one_shot_wd(one_shot_wd),
    .sclk(sclk), .free_run(free_run), .one_shot(one_shot)
  );

  // Width monitor: every high level must last HALF cycles (R3, R9).
  always @(negedge clk) begin
    if (rst_n) begin
      if (sclk) hi_run <= hi_run + 1;
      if (prev_sclk && !sclk) begin
        pulses <= pulses + 1;
        if (hi_run != HALF) bad_width <= bad_width + 1;
        hi_run <= 0;
      end
    end
    prev_sclk <= sclk;
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_fr(input logic v);
    free_run_we = 1; free_run_wd = v; cyc(1); free_run_we = 0;
  endtask

  task automatic wr_os(input logic v);
    one_shot_we = 1; one_shot_wd = v; cyc(1); one_shot_we = 0;
  endtask

  task automatic t_reset;
    cyc(1);
    check("R1 sclk idle", int'(sclk), 0);
    check("R1 free_run", int'(free_run), 0);
    check("R1 one_shot", int'(one_shot), 0);
  endtask

  task automatic t_idle;
    int p0;
    p0 = pulses;
    cyc(30);
    check("R4 no pulses when idle", pulses - p0, 0);
  endtask

  task automatic t_tx;
    int p0;
    p0 = pulses;
    tx_busy = 1; cyc(8 * HALF * 2); tx_busy = 0;
    cyc(4 * HALF);
    check("R4 tx pulses", int'(pulses - p0 >= 6), 1);
    check("R9 idle after tx", int'(sclk), 0);
  endtask

  task automatic t_rx;
    int p0;
    p0 = pulses;
    rx_active = 1; cyc(5 * HALF * 2); rx_active = 0;
    cyc(4 * HALF);
    check("R5 rx pulses", int'(pulses - p0 >= 3), 1);
    check("R5 idle after rx", int'(sclk), 0);
  endtask

  task automatic t_free_run;
    int p0, n;
    wr_fr(1);
    check("R2 free_run written", int'(free_run), 1);
    p0 = pulses;
    cyc(10 * HALF * 2);
    check("R6 free-run pulses", int'(pulses - p0 >= 8), 1);
    while (sclk) cyc(1);
    while (!sclk) cyc(1);
    n = 0;
    while (sclk) begin cyc(1); n++; end
    while (!sclk) begin cyc(1); n++; end
    check("R3 period", n, 2 * HALF);
    wr_fr(0);
    check("R2 free_run cleared", int'(free_run), 0);
    cyc(4 * HALF);
    p0 = pulses;
    cyc(20);
    check("R9 stopped after clear", pulses - p0, 0);
    check("R9 idle level", int'(sclk), 0);
  endtask

  task automatic t_stop_mid;
    int p0;
    tx_busy = 1;
    while (!sclk) cyc(1);
    tx_busy = 0;
    p0 = pulses;
    cyc(4 * HALF);
    check("R9 pulse completes", pulses - p0, 1);
    check("R9 idle after mid stop", int'(sclk), 0);
  endtask

  task automatic t_auto_clear;
    int p0;
    wr_os(1); wr_fr(1);
    check("R2 one_shot written", int'(one_shot), 1);
    cyc(2 * HALF + 1);
    while (!sclk) cyc(1);
    rx_char_done = 1; cyc(1); rx_char_done = 0;
    check("R7 free_run auto-cleared", int'(free_run), 0);
    check("R7 one_shot auto-cleared", int'(one_shot), 0);
    cyc(4 * HALF);
    p0 = pulses;
    cyc(20);
    check("R9 stopped after auto-clear", pulses - p0, 0);
  endtask

  task automatic t_no_one_shot;
    wr_fr(1);
    rx_char_done = 1; cyc(1); rx_char_done = 0;
    check("R8 free_run kept", int'(free_run), 1);
    cyc(3);
    check("R8 free_run still kept", int'(free_run), 1);
    wr_fr(0);
    cyc(4 * HALF);
  endtask

  task automatic t_conflict;
    wr_os(1); wr_fr(1);
    rx_char_done = 1; free_run_we = 1; free_run_wd = 1;
    one_shot_we = 1; one_shot_wd = 1;
    cyc(1);
    rx_char_done = 0; free_run_we = 0; one_shot_we = 0;
    check("R10 free_run cleared over write", int'(free_run), 0);
    check("R10 one_shot cleared over write", int'(one_shot), 0);
    cyc(4 * HALF);
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    t_reset();
    t_idle();
    t_tx();
    t_rx();
    t_free_run();
    t_stop_mid();
    t_auto_clear();
    t_no_one_shot();
    t_conflict();
    check("R3 R9 pulse widths", bad_width, 0);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule